// File: doc/BRIEF.md
# Cycle-Driven Scanline Interrupt Counter

This block raises an interrupt after a programmed number of display lines, although it never sees the video timing. It only counts CPU cycles. A fractional prescaler turns cycles into line ticks, averaging 113 and two-thirds cycles per tick. It does this with a repeating period pattern of 114, 114, 113. An 8-bit up-counter counts those ticks. When it is clocked at its top value, it reloads from a programmable reload register and sets a sticky interrupt flag. A mode bit bypasses the prescaler, so the counter then advances on every CPU cycle.

Software reaches the block through write strobes that share an 8-bit data bus:
- A reload write sets all eight bits of the reload value. Separate low-nibble and high-nibble strobes can also set it four bits at a time.
- A control write sets the mode, the live enable and an armed "enable again after acknowledge" bit.
- An acknowledge write clears the flag and copies the armed bit into the live enable.

The `cyc_en` input marks the clock cycles that are CPU cycles. The block keeps counting through blanking and with the display off.

Top module: `scan_irq_timer`

## Requirements
- R1: After reset `irq` is 0, the live enable, armed and mode bits are 0, the reload value and counter are 0, and the prescaler is full. No interrupt occurs until a control write sets the enable.
- R2: A reload write (`wr_rld`) loads all 8 bits of `wdata` into the reload value.
- R3: `wr_rld_lo` loads `wdata[3:0]` into reload bits 3:0, and `wr_rld_hi` loads `wdata[3:0]` into reload bits 7:4. The other nibble is kept.
- R4: A control write stores `wdata[0]` as armed, `wdata[1]` as enable and `wdata[2]` as mode (1 = every cycle, 0 = line ticks). It ignores `wdata[7:3]`, and it clears a pending interrupt.
- R5: A control write with `wdata[1]`=1 reloads the counter from the reload value and restarts the prescaler. A control write with `wdata[1]`=0 leaves both unchanged.
- R6: An acknowledge write clears a pending interrupt and copies the armed bit into the enable, whatever `wdata` holds. The counter and prescaler are left as they are.
- R7: In line mode the counter is clocked 114, 114, then 113 enabled cycles apart, repeating. The first clock comes 114 cycles after a prescaler restart.
- R8: In every-cycle mode the counter is clocked on every enabled cycle.
- R9: With the enable clear, or `cyc_en` low, neither the prescaler nor the counter advances.
- R10: A counter clock at 0xFF reloads the counter from the reload value and sets `irq`. `irq` stays 1 until a control or acknowledge write.
- R11: When an overflow and an acknowledging write fall in the same cycle, `irq` stays set. A control write with `wdata[1]`=1 overrides the counting step in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Marks a CPU cycle |
| wr_rld | input | 1 | Full reload-value write strobe |
| wr_rld_lo | input | 1 | Low-nibble reload write strobe |
| wr_rld_hi | input | 1 | High-nibble reload write strobe |
| wr_ctrl | input | 1 | Control write strobe |
| wr_ack | input | 1 | Acknowledge write strobe |
| wdata | input | 8 | Write data |
| irq | output | 1 | Active-high interrupt request |

## Verification
Every write takes effect at the clock edge where its strobe is sampled. The `irq` flag changes at that same edge, so the bench reads it half a period later. The bench's behavioural model advances on each rising edge from the same inputs, and it is compared with `irq` on every falling edge.

The bench counts overflow latency in falling edges from the edge of the enabling write:
- In every-cycle mode, an overflow is expected N edges later, where N is 0x100 minus the start value.
- In line mode, rises are expected at cumulative offsets of 114, 228, 341 and 455, with each acknowledge edge counted.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  typedef struct packed {
    logic mode;
    logic en;
    logic arm;
  } irq_ctrl_t;

  // Next accumulator value of the fractional prescaler for one step.
  function automatic logic [15:0] pre_next(input logic [15:0] acc,
                                           input logic [15:0] step,
                                           input logic [15:0] period);
    if (acc <= step) pre_next = acc + period - step;
    else             pre_next = acc - step;
  endfunction

  // True when one step of the accumulator emits a counter clock.
  function automatic logic pre_fires(input logic [15:0] acc,
                                     input logic [15:0] step);
    pre_fires = (acc <= step);
  endfunction

endpackage

// File: rtl/scan_irq_ctrl.sv
module scan_irq_ctrl #(
  parameter int DW    = 8,
  parameter int NIB_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rld,
  input  logic          wr_rld_lo,
  input  logic          wr_rld_hi,
  input  logic          wr_ctrl,
  input  logic          wr_ack,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rld_q,
  output scan_irq_pkg::irq_ctrl_t ctl_q,
  output logic          restart_evt
);
  import scan_irq_pkg::*;

  localparam int NNIB = DW / NIB_W;

  logic [NNIB-1:0] nib_wr;
  assign nib_wr = {wr_rld_hi, wr_rld_lo};

  genvar g;
  generate
    for (g = 0; g < NNIB; g++) begin : g_nib
      always_ff @(posedge clk) begin
        if (!rst_n)
          rld_q[g*NIB_W +: NIB_W] <= '0;
        else if (wr_rld)
          rld_q[g*NIB_W +: NIB_W] <= wdata[g*NIB_W +: NIB_W];
        else if (nib_wr[g])
          rld_q[g*NIB_W +: NIB_W] <= wdata[NIB_W-1:0];
      end
    end
  endgenerate

  assign restart_evt = wr_ctrl && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctrl) begin
      ctl_q.arm  <= wdata[0];
      ctl_q.en   <= wdata[1];
      ctl_q.mode <= wdata[2];
    end else if (wr_ack) begin
      ctl_q.en <= ctl_q.arm;
    end
  end
endmodule

// File: rtl/scan_irq_prescaler.sv
module scan_irq_prescaler #(
  parameter int PERIOD = 341,
  parameter int STEP   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic adv,
  input  logic bypass,
  output logic [$clog2(PERIOD+1)-1:0] acc_q,
  output logic tick
);
  import scan_irq_pkg::*;

  localparam int PW = $clog2(PERIOD + 1);
  localparam logic [15:0] P16 = 16'(PERIOD);
  localparam logic [15:0] S16 = 16'(STEP);

  logic [15:0] acc_w, nxt_w;
  logic        fire_w;

  assign acc_w  = 16'(acc_q);
  assign nxt_w  = pre_next(acc_w, S16, P16);
  assign fire_w = pre_fires(acc_w, S16);
  assign tick   = adv && (bypass || fire_w);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) acc_q <= PW'(PERIOD);
    else if (adv && !bypass) acc_q <= nxt_w[PW-1:0];
  end
endmodule

// File: rtl/scan_irq_counter.sv
module scan_irq_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          tick,
  input  logic [CW-1:0] rld_val,
  output logic [CW-1:0] cnt_q,
  output logic          ovf_evt
);
  localparam logic [CW-1:0] TOP = '1;

  assign ovf_evt = tick && !reload && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (reload || ovf_evt) cnt_q <= rld_val;
    else if (tick)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scan_irq_timer.sv
module scan_irq_timer #(
  parameter int DW     = 8,
  parameter int PERIOD = 341,
  parameter int STEP   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic          wr_rld,
  input  logic          wr_rld_lo,
  input  logic          wr_rld_hi,
  input  logic          wr_ctrl,
  input  logic          wr_ack,
  input  logic [DW-1:0] wdata,
  output logic          irq
);
  import scan_irq_pkg::*;

  localparam int PW = $clog2(PERIOD + 1);

  logic [DW-1:0] rld_q;
  irq_ctrl_t     ctl_q;
  logic          restart_evt;
  logic          adv;
  logic          pre_tick;
  logic [PW-1:0] pre_q;
  logic [DW-1:0] cnt_q;
  logic          ovf_evt;
  logic          pend_q;

  scan_irq_ctrl #(.DW(DW), .NIB_W(DW/2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_rld(wr_rld), .wr_rld_lo(wr_rld_lo),
    .wr_rld_hi(wr_rld_hi), .wr_ctrl(wr_ctrl), .wr_ack(wr_ack),
    .wdata(wdata), .rld_q(rld_q), .ctl_q(ctl_q), .restart_evt(restart_evt)
  );

  assign adv = cyc_en && ctl_q.en && !restart_evt;

  scan_irq_prescaler #(.PERIOD(PERIOD), .STEP(STEP)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart_evt), .adv(adv),
    .bypass(ctl_q.mode), .acc_q(pre_q), .tick(pre_tick)
  );

  scan_irq_counter #(.CW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .reload(restart_evt), .tick(pre_tick),
    .rld_val(rld_q), .cnt_q(cnt_q), .ovf_evt(ovf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (ovf_evt)            pend_q <= 1'b1;
    else if (wr_ctrl || wr_ack)  pend_q <= 1'b0;
  end

  assign irq = pend_q;
endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
  parameter int DW     = 8,
  parameter int PERIOD = 341,
  parameter int PW     = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_en,
  input logic          wr_ctrl,
  input logic          wr_ack,
  input logic [DW-1:0] wdata,
  input logic          irq,
  input logic          en_q,
  input logic          arm_q,
  input logic          mode_q,
  input logic [DW-1:0] rld_q,
  input logic [DW-1:0] cnt_q,
  input logic [PW-1:0] pre_q,
  input logic          pre_tick,
  input logic          ovf_evt
);
  a_r10_ovf_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> irq);

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ctrl && !wr_ack) |=> irq);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !ovf_evt) |=> !irq);

  a_r6_ack_copies_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !wr_ctrl) |=> (en_q == $past(arm_q)));

  a_r5_restart_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[1]) |=> (cnt_q == $past(rld_q) && pre_q == PW'(PERIOD)));

  a_r9_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en_q || !cyc_en) && !wr_ctrl) |=> ($stable(cnt_q) && $stable(pre_q)));

  a_r8_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q && cyc_en && !wr_ctrl && !(&cnt_q)) |=>
      (cnt_q == $past(cnt_q) + 1'b1));

  a_r7_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q >= 1 && pre_q <= PW'(PERIOD)));

  a_r7_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> (cyc_en && en_q));
endmodule

bind scan_irq_timer scan_irq_chk #(.DW(DW), .PERIOD(PERIOD), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_ctrl(wr_ctrl),
  .wr_ack(wr_ack), .wdata(wdata), .irq(irq), .en_q(ctl_q.en),
  .arm_q(ctl_q.arm), .mode_q(ctl_q.mode), .rld_q(rld_q), .cnt_q(cnt_q),
  .pre_q(pre_q), .pre_tick(pre_tick), .ovf_evt(ovf_evt)
);

// File: tb/sim_scan_irq_timer.sv
`timescale 1ns/1ps
module sim_scan_irq_timer;
  logic clk = 0, rst_n = 0, cyc_en = 1;
  logic wr_rld = 0, wr_rld_lo = 0, wr_rld_hi = 0, wr_ctrl = 0, wr_ack = 0;
  logic [7:0] wdata = 0;
  logic irq;
  int n_run = 0, n_fail = 0;
  string tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  scan_irq_timer u0 (.clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_rld(wr_rld),
    .wr_rld_lo(wr_rld_lo), .wr_rld_hi(wr_rld_hi), .wr_ctrl(wr_ctrl),
    .wr_ack(wr_ack), .wdata(wdata), .irq(irq));

  // Behavioural reference: signed scanline budget in thirds of a cycle.
  int m_pre, m_cnt, m_rld, m_e, m_a, m_m, m_irq;
  int nx_irq, ov, tk;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 341; m_cnt = 0; m_rld = 0; m_e = 0; m_a = 0; m_m = 0; m_irq = 0;
    end else begin
      ov = 0;
      if (wr_ctrl && wdata[1]) begin
        m_cnt = m_rld; m_pre = 341;
      end else if (cyc_en && m_e != 0) begin
        tk = 1;
        if (m_m == 0) begin
          m_pre = m_pre - 3;
          tk = (m_pre <= 0);
          if (tk != 0) m_pre = m_pre + 341;
        end
        if (tk != 0) begin
          if (m_cnt == 255) begin m_cnt = m_rld; ov = 1; end
          else m_cnt = m_cnt + 1;
        end
      end
      nx_irq = m_irq;
      if (ov != 0) nx_irq = 1;
      else if (wr_ctrl || wr_ack) nx_irq = 0;
      m_irq = nx_irq;
      if (wr_ctrl) begin m_a = wdata[0]; m_e = wdata[1]; m_m = wdata[2]; end
      else if (wr_ack) m_e = m_a;
      if (wr_rld) m_rld = wdata;
      else begin
        if (wr_rld_lo) m_rld = (m_rld & 8'hF0) | wdata[3:0];
        if (wr_rld_hi) m_rld = (m_rld & 8'h0F) | (int'(wdata[3:0]) << 4);
      end
    end
  end

  task automatic check(input string t, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) check({tag, " model"}, irq == m_irq[0], irq, m_irq);

  // kind: 0 full reload, 1 low nibble, 2 high nibble, 3 control, 4 acknowledge
  task automatic wr(input int kind, input logic [7:0] d);
    wdata = d;
    wr_rld = (kind == 0); wr_rld_lo = (kind == 1); wr_rld_hi = (kind == 2);
    wr_ctrl = (kind == 3); wr_ack = (kind == 4);
    @(negedge clk);
    {wr_rld, wr_rld_lo, wr_rld_hi, wr_ctrl, wr_ack} = '0;
    wdata = 0;
  endtask

  task automatic wait_irq(output int n, input int lim);
    n = 0;
    while (!irq && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    check("watchdog", 0, 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, tot;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq after reset", irq == 0, irq, 0);
    idle(400);
    check("R1 no irq while disabled", irq == 0, irq, 0);

    tag = "R8";
    wr(0, 8'hFC);
    wr(3, 8'h06);
    wait_irq(n, 600);
    check("R2/R8 cycle mode overflow latency", n == 4, n, 4);
    idle(10);
    check("R10 irq held", irq == 1, irq, 1);
    tag = "R6";
    wr(4, 8'hFF);
    check("R6 ack clears", irq == 0, irq, 0);
    idle(50);
    check("R6 data ignored, enable from armed=0", irq == 0, irq, 0);

    tag = "R3";
    wr(1, 8'hAD);
    wr(2, 8'h5F);
    wr(3, 8'h06);
    wait_irq(n, 600);
    check("R3 nibble reload 0xFD", n == 3, n, 3);
    tag = "R4";
    wr(3, 8'h00);
    check("R4 control write clears irq", irq == 0, irq, 0);

    tag = "R7";
    wr(0, 8'hFF);
    wr(3, 8'h03);
    tot = 0;
    for (int i = 0; i < 4; i++) begin
      int exp_t;
      wait_irq(n, 600);
      tot += n;
      exp_t = (i == 0) ? 114 : (i == 1) ? 228 : (i == 2) ? 341 : 455;
      check("R7 line tick spacing", tot == exp_t, tot, exp_t);
      wr(4, 8'h00);
      tot += 1;
    end

    tag = "R4";
    wr(3, 8'hFA);
    wait_irq(n, 600);
    check("R4 upper bits ignored, line mode", n == 114, n, 114);
    wr(4, 8'h00);
    idle(300);
    check("R4 armed=0 from 0xFA stops counting", irq == 0, irq, 0);

    tag = "R9";
    wr(0, 8'hFC);
    cyc_en = 0;
    wr(3, 8'h06);
    idle(30);
    check("R9 cyc_en low freezes", irq == 0, irq, 0);
    cyc_en = 1;
    wait_irq(n, 600);
    check("R9 resumes after cyc_en", n == 4, n, 4);
    wr(3, 8'h00);

    tag = "R5";
    wr(0, 8'hF0);
    wr(3, 8'h06);
    idle(4);
    wr(3, 8'h05);
    wr(0, 8'h00);
    wr(4, 8'h00);
    wait_irq(n, 600);
    check("R5/R6 no reload on E=0, ack re-enables", n == 11, n, 11);
    wr(3, 8'h00);

    tag = "R11";
    wr(0, 8'hFC);
    wr(3, 8'h07);
    wait_irq(n, 600);
    check("R11 setup overflow", n == 4, n, 4);
    idle(3);
    wr(4, 8'h00);
    check("R11 overflow beats ack", irq == 1, irq, 1);
    wr(4, 8'h00);
    for (int i = 0; i < 20; i++) wr(3, 8'h06);
    check("R11 restart overrides counting", irq == 0, irq, 0);
    wr(3, 8'h00);
    idle(5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule